// File: doc/BRIEF.md
# Event-Driven Leaky Integrate-and-Fire Neuron Update Unit

This unit brings one leaky integrate-and-fire neuron up to date each time an input spike reaches it. It accepts the neuron's 64-bit state record, the synaptic weight of the arriving spike and the current 24-bit timestamp. It does not decay the membrane on every time step. It measures the time that has passed since the neuron was last touched and uses that span to index a table of exponential decay factors. It then applies the factor, adds the weight and decides whether the neuron fires. The updated record and a fire flag leave the unit two cycles after the input is accepted.

A neuron engine puts one of these units behind its state fetch and in front of its state write-back. Input and output each use a valid/ready handshake. Back-pressure on the output stalls the whole pipeline, so results come out in input order. The threshold, the reset potential, the refractory length and the number of ticks per table step are parameters.

State record layout, from most to least significant bit:
- [63:48] refractory end time
- [47:24] last-update time
- [23:8] membrane value, signed, 5 integer bits and 11 fractional bits
- [7:0] flags byte: bit 0 is the initialization bit, bit 1 is the refractory bit, bits 7:2 are a tag

Weights use the same signed fixed-point format as the membrane.

Top module: `lif_update_unit`

## Requirements
- R1: Flag bits 7:2 of the record (the tag) come out unchanged. The refractory end time passes through unchanged unless the neuron fires.
- R2: Every output record has its last-update field equal to the input timestamp and its initialization bit (bit 0) set.
- R3: The decay index is the elapsed time shifted right by DT_SHIFT. The factor is round(e^(-index/128)·2048), and the decayed membrane is floor(membrane·factor/2048). An index of 0 leaves the membrane unchanged.
- R4: A decay index of 1024 or more gives a factor of zero, so the new membrane equals the weight alone.
- R5: The sum of the decayed membrane and the weight saturates to the range -32768 to 32767 instead of wrapping.
- R6: When the sum is strictly greater than THRESH and the neuron is not refractory, the fire flag is 1. The membrane becomes RESET_POT, the refractory bit is set and the refractory end becomes timestamp[15:0] + REF_PERIOD. A sum equal to THRESH does not fire.
- R7: A neuron is refractory when its refractory bit is set and (refractory end − timestamp[15:0]), taken as a signed 16-bit value, is positive. A refractory neuron never fires and keeps the unclamped-by-reset sum and its refractory bit. A neuron that is not refractory and does not fire leaves with the refractory bit clear.
- R8: A record whose initialization bit is clear is treated as a membrane of 0 that is not refractory.
- R9: A result appears on the output two cycles after its input handshake. While outValid is high and outReady is low, the output holds stable. Results leave in input order.
- R10: While reset is asserted and right after it, outValid is low.
- R11: The elapsed time is the timestamp minus the last-update field, modulo 2^24, so counter wrap decays correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input spike update is offered |
| inReady | output | 1 | Unit accepts the offered update |
| inState | input | 64 | Neuron state record before the update |
| inWeight | input | 16 | Signed synaptic weight, Q5.11 |
| inNow | input | 24 | Current timestamp |
| outValid | output | 1 | Updated record is available |
| outReady | input | 1 | Consumer takes the record |
| outState | output | 64 | Neuron state record after the update |
| outFire | output | 1 | The neuron fired on this update |

## Verification
The bench builds the unit with DT_SHIFT = 2, THRESH = 2048 (1.0), RESET_POT = −512 and REF_PERIOD = 20. With four ticks per table step, an elapsed time of 4096 or more reaches the saturated end of the table. A short refractory window lets both sides of the refractory boundary be reached in a few updates. A negative reset potential makes a reset membrane distinct from a zero membrane. The bench's reference computes the decay factor with real arithmetic and accepts a factor within one code of it. It drives directed corner cases, then a random burst under random output back-pressure.

// File: rtl/lif_pkg.sv
package lif_pkg;
  localparam int TIME_W   = 24;
  localparam int REF_W    = 16;
  localparam int MEM_W    = 16;
  localparam int FLAG_W   = 8;
  localparam int FRAC_W   = 11;
  localparam int INIT_BIT = 0;
  localparam int REFR_BIT = 1;
  localparam int REC_W    = REF_W + TIME_W + MEM_W + FLAG_W;

  typedef struct packed {
    logic [REF_W-1:0]         refEnd;
    logic [TIME_W-1:0]        lastTime;
    logic signed [MEM_W-1:0]  membrane;
    logic [FLAG_W-1:0]        flags;
  } lifState_t;

  typedef struct packed {
    logic ldFetch;
    logic ldCompute;
  } lifStrobe_t;
endpackage

// File: rtl/lif_decay_rom.sv
module lif_decay_rom #(
  parameter int AW   = 10,
  parameter int FRAC = 11
) (
  input  logic [AW-1:0] idx,
  output logic [FRAC:0] factor
);
  localparam int DEPTH = 1 << AW;
  // round(2^30 * e^(-1/128)): one table step is 1/128 of the time constant
  localparam longint unsigned STEP_Q30 = 64'd1065385899;
  localparam longint unsigned ONE_Q30  = 64'd1 << 30;
  localparam longint unsigned HALF_Q30 = 64'd1 << 29;

  // square-and-multiply of the per-step factor, rounded to FRAC bits at the end
  function automatic logic [FRAC:0] expEntry(input int j);
    longint unsigned acc;
    longint unsigned base;
    acc  = ONE_Q30;
    base = STEP_Q30;
    for (int b = 0; b < AW; b++) begin
      if (j[b]) acc = (acc * base + HALF_Q30) >> 30;
      base = (base * base + HALF_Q30) >> 30;
    end
    return (FRAC+1)'((acc + (64'd1 << (29 - FRAC))) >> (30 - FRAC));
  endfunction

  logic [FRAC:0] romTbl [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_rom
    assign romTbl[gi] = expEntry(gi);
  end

  assign factor = romTbl[idx];
endmodule

// File: rtl/lif_ctrl.sv
module lif_ctrl
  import lif_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output lifStrobe_t strobe
);
  logic s1Valid;
  logic advance;

  assign advance          = !outValid || outReady;
  assign inReady          = advance;
  assign strobe.ldFetch   = advance && inValid;
  assign strobe.ldCompute = advance && s1Valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      outValid <= 1'b0;
    end else if (advance) begin
      s1Valid  <= inValid;
      outValid <= s1Valid;
    end
  end

  AST_STALL_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid); // R9
  AST_ACCEPT_REACHES_OUT: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && outReady |=> ##1 (outValid || !$past(outReady))); // R9
endmodule

// File: rtl/lif_dpath.sv
module lif_dpath
  import lif_pkg::*;
#(
  parameter int DT_SHIFT   = 0,
  parameter int ROM_AW     = 10,
  parameter int THRESH     = 2048,
  parameter int RESET_POT  = 0,
  parameter int REF_PERIOD = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  lifStrobe_t              strobe,
  input  lifState_t               inRec,
  input  logic signed [MEM_W-1:0] inWeight,
  input  logic [TIME_W-1:0]       inNow,
  output lifState_t               outRec,
  output logic                    outFire
);
  localparam int MAXV  = (1 << (MEM_W - 1)) - 1;
  localparam int MINV  = -(1 << (MEM_W - 1));
  localparam int PROD_W = MEM_W + FRAC_W + 2;

  // ---------------- stage 1: elapsed time, table lookup, refractory test
  logic [TIME_W-1:0] elapsed;
  logic [TIME_W-1:0] idxWide;
  logic              idxSat;
  logic [FRAC_W:0]   romFactor;
  logic [REF_W-1:0]  refLeft;
  logic              initOk;
  logic              inRefr;

  assign initOk  = inRec.flags[INIT_BIT];
  assign elapsed = inNow - inRec.lastTime;
  assign idxWide = elapsed >> DT_SHIFT;
  assign idxSat  = |idxWide[TIME_W-1:ROM_AW];
  assign refLeft = inRec.refEnd - inNow[REF_W-1:0];
  assign inRefr  = initOk && inRec.flags[REFR_BIT] && ($signed(refLeft) > 0);

  lif_decay_rom #(.AW(ROM_AW), .FRAC(FRAC_W)) u_rom (
    .idx    (idxWide[ROM_AW-1:0]),
    .factor (romFactor)
  );

  logic signed [MEM_W-1:0] s1Mem;
  logic signed [MEM_W-1:0] s1Weight;
  logic [FRAC_W:0]         s1Factor;
  logic [TIME_W-1:0]       s1Now;
  logic [REF_W-1:0]        s1RefEnd;
  logic [FLAG_W-3:0]       s1Tag;
  logic                    s1Refr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Mem    <= '0;
      s1Weight <= '0;
      s1Factor <= '0;
      s1Now    <= '0;
      s1RefEnd <= '0;
      s1Tag    <= '0;
      s1Refr   <= 1'b0;
    end else if (strobe.ldFetch) begin
      s1Mem    <= initOk ? inRec.membrane : '0;
      s1Weight <= inWeight;
      s1Factor <= idxSat ? '0 : romFactor;
      s1Now    <= inNow;
      s1RefEnd <= inRec.refEnd;
      s1Tag    <= inRec.flags[FLAG_W-1:2];
      s1Refr   <= inRefr;
    end
  end

  // ---------------- stage 2: multiply, add, saturate, compare
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;
  logic signed [MEM_W-1:0]  decayed;
  logic signed [MEM_W:0]    sumWide;
  logic signed [MEM_W-1:0]  sumSat;
  logic                     fireNow;
  lifState_t                nextRec;

  assign prod    = s1Mem * $signed({1'b0, s1Factor});
  assign shifted = prod >>> FRAC_W;
  assign decayed = shifted[MEM_W-1:0];
  assign sumWide = decayed + s1Weight;

  always_comb begin
    if (sumWide > MAXV)      sumSat = MEM_W'(MAXV);
    else if (sumWide < MINV) sumSat = MEM_W'(MINV);
    else                     sumSat = sumWide[MEM_W-1:0];
  end

  assign fireNow = (sumSat > THRESH) && !s1Refr;

  always_comb begin
    nextRec.refEnd   = fireNow ? s1Now[REF_W-1:0] + REF_W'(REF_PERIOD) : s1RefEnd;
    nextRec.lastTime = s1Now;
    nextRec.membrane = fireNow ? MEM_W'(RESET_POT) : sumSat;
    nextRec.flags    = {s1Tag, fireNow || s1Refr, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outRec  <= '0;
      outFire <= 1'b0;
    end else if (strobe.ldCompute) begin
      outRec  <= nextRec;
      outFire <= fireNow;
    end
  end

  logic signed [MEM_W:0] magIn;
  logic signed [MEM_W:0] magOut;
  assign magIn  = (s1Mem < 0) ? -(MEM_W+1)'(s1Mem) : (MEM_W+1)'(s1Mem);
  assign magOut = (decayed < 0) ? -(MEM_W+1)'(decayed) : (MEM_W+1)'(decayed);

  AST_DECAY_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldCompute |-> magOut <= magIn); // R3
  AST_REFR_BLOCKS_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldCompute && s1Refr |=> !outFire); // R7
endmodule

// File: rtl/lif_update_unit.sv
module lif_update_unit
  import lif_pkg::*;
#(
  parameter int DT_SHIFT   = 0,
  parameter int ROM_AW     = 10,
  parameter int THRESH     = 2048,
  parameter int RESET_POT  = 0,
  parameter int REF_PERIOD = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [REC_W-1:0]        inState,
  input  logic [MEM_W-1:0]        inWeight,
  input  logic [TIME_W-1:0]       inNow,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [REC_W-1:0]        outState,
  output logic                    outFire
);
  lifStrobe_t strobe;
  lifState_t  outRec;

  lif_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  lif_dpath #(
    .DT_SHIFT   (DT_SHIFT),
    .ROM_AW     (ROM_AW),
    .THRESH     (THRESH),
    .RESET_POT  (RESET_POT),
    .REF_PERIOD (REF_PERIOD)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inRec    (lifState_t'(inState)),
    .inWeight ($signed(inWeight)),
    .inNow    (inNow),
    .outRec   (outRec),
    .outFire  (outFire)
  );

  assign outState = outRec;

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outState) && $stable(outFire)); // R9
  AST_FIRE_RESETS: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outFire |-> outRec.membrane == MEM_W'(RESET_POT) && outRec.flags[REFR_BIT]); // R6
  AST_INIT_WRITTEN: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outRec.flags[INIT_BIT]); // R2
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
    !rstN |=> !outValid); // R10
endmodule

// File: tb/sim_lif_update_unit.sv
module sim_lif_update_unit;
  localparam int DT_SHIFT = 2;
  localparam int THRESH   = 2048;
  localparam int RST_POT  = -512;
  localparam int REF_P    = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] inState = '0;
  logic [15:0] inWeight = '0;
  logic [23:0] inNow = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [63:0] outState;
  logic        outFire;

  int checks = 0;
  int fails  = 0;
  bit bpOn   = 1'b0;

  logic [63:0] qState [$];
  logic [15:0] qWeight [$];
  logic [23:0] qNow [$];
  string       qReq [$];

  always #10 clk = ~clk;

  lif_update_unit #(
    .DT_SHIFT(DT_SHIFT), .ROM_AW(10), .THRESH(THRESH),
    .RESET_POT(RST_POT), .REF_PERIOD(REF_P)
  ) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inState(inState), .inWeight(inWeight), .inNow(inNow),
    .outValid(outValid), .outReady(outReady), .outState(outState), .outFire(outFire)
  );

  function automatic logic [63:0] mk(logic [15:0] refEnd, logic [23:0] last,
                                     logic [15:0] mem, logic [7:0] flags);
    return {refEnd, last, mem, flags};
  endfunction

  // reference model for one factor value; result is {record, fire}
  function automatic logic [64:0] model(logic [63:0] st, logic [15:0] w,
                                        logic [23:0] now, int f);
    logic        init;
    logic        refr;
    logic [15:0] left;
    int          mem, d, s;
    logic        fire;
    logic [15:0] refEnd;
    logic [15:0] memOut;
    init = st[0];
    mem  = init ? int'($signed(st[23:8])) : 0;
    left = st[63:48] - now[15:0];
    refr = init && st[1] && ($signed(left) > 0);
    d = (mem * f) >>> 11;
    s = d + int'($signed(w));
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    fire   = (s > THRESH) && !refr;
    refEnd = fire ? now[15:0] + 16'(REF_P) : st[63:48];
    memOut = fire ? 16'(RST_POT) : 16'(s);
    return {refEnd, now, memOut, st[7:2], fire || refr, 1'b1, fire};
  endfunction

  function automatic int nominalFactor(logic [63:0] st, logic [23:0] now);
    int idx;
    logic [23:0] dt;
    dt  = now - st[47:24];
    idx = int'(dt) >> DT_SHIFT;
    if (idx >= 1024) return 0;
    return $rtoi($exp(-real'(idx) / 128.0) * 2048.0 + 0.5);
  endfunction

  task automatic send(logic [63:0] st, logic [15:0] w, logic [23:0] now, string req);
    @(negedge clk);
    inState  = st;
    inWeight = w;
    inNow    = now;
    inValid  = 1'b1;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    qState.push_back(st);
    qWeight.push_back(w);
    qNow.push_back(now);
    qReq.push_back(req);
    @(posedge clk);
    #1 inValid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((qState.size() != 0) && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  // monitor: sets outReady for the next edge, checks results and stall stability
  logic [64:0] held;
  bit          wasStalled = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (wasStalled) begin
        checks++;
        if (!outValid || {outState, outFire} !== held) begin
          fails++;
          $display("FAIL R9 stalled output moved: actual %h/%0b expected %h", outState, outFire, held);
        end
      end
      outReady = bpOn ? ($urandom_range(0, 2) != 0) : 1'b1;
      wasStalled = outValid && !outReady;
      held = {outState, outFire};
      if (outValid && outReady && rstN) begin
        checks++;
        if (qState.size() == 0) begin
          fails++;
          $display("FAIL R9 unexpected output: actual %h expected none", outState);
        end else begin
          logic [63:0] st;
          logic [15:0] w;
          logic [23:0] now;
          string req;
          int fn;
          bit ok;
          logic [64:0] exp0;
          st = qState.pop_front();
          w = qWeight.pop_front();
          now = qNow.pop_front();
          req = qReq.pop_front();
          fn = nominalFactor(st, now);
          exp0 = model(st, w, now, fn);
          ok = ({outState, outFire} === exp0);
          if (fn != 0 && fn != 2048) begin
            if ({outState, outFire} === model(st, w, now, fn - 1)) ok = 1'b1;
            if ({outState, outFire} === model(st, w, now, fn + 1)) ok = 1'b1;
          end
          if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h fire %0b expected %h fire %0b",
                     req, outState, outFire, exp0[64:1], exp0[0]);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    // R10: idle during and after reset
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      fails++;
      $display("FAIL R10 in reset: actual %b expected 0", outValid);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || inReady !== 1'b1) begin
      fails++;
      $display("FAIL R10 after reset: actual %b/%b expected 0/1", outValid, inReady);
    end

    // R9: latency of two cycles
    send(mk(16'h0, 24'd100, 16'd1000, 8'h01), 16'd0, 24'd100, "R9 latency");
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      fails++;
      $display("FAIL R9 early output: actual %b expected 0", outValid);
    end
    @(negedge clk);
    checks++;
    if (outValid !== 1'b1) begin
      fails++;
      $display("FAIL R9 late output: actual %b expected 1", outValid);
    end
    drain();

    // R1, R2, R8: uninitialized record, tag kept, weight 0.5 only
    send(mk(16'h1234, 24'd7, 16'h7000, 8'hA6), 16'd1024, 24'd500, "R1,R2,R8 uninit");
    // R3: zero elapsed keeps membrane
    send(mk(16'h0, 24'd300, 16'd1000, 8'h01), 16'd100, 24'd300, "R3 zero elapsed");
    // R3: one time constant (index 128)
    send(mk(16'h0, 24'd1000, 16'd2000, 8'h05), 16'd0, 24'd1512, "R3 one tau");
    // R3: negative membrane, index 64
    send(mk(16'h0, 24'd0, -16'sd1000, 8'h01), 16'd0, 24'd256, "R3 negative decay");
    // R4: saturated index
    send(mk(16'h0, 24'd10, 16'd3000, 8'h01), 16'd300, 24'd4106, "R4 beyond table");
    send(mk(16'h0, 24'd10, 16'd3000, 8'h01), 16'd300, 24'd5000, "R4 far beyond table");
    // R6: fire, and equality does not fire
    send(mk(16'h0, 24'd40, 16'd2000, 8'h01), 16'd100, 24'd40, "R6 fire");
    send(mk(16'h0, 24'd40, 16'd2000, 8'h01), 16'd48, 24'd40, "R6 equal no fire");
    // R7: refractory blocks fire; end reached allows fire
    send(mk(16'd65, 24'd60, 16'd2400, 8'h03), 16'd100, 24'd60, "R7 refractory");
    send(mk(16'd60, 24'd60, 16'd2400, 8'h03), 16'd100, 24'd60, "R7 end reached");
    send(mk(16'd50, 24'd60, 16'd100, 8'h03), 16'd10, 24'd60, "R7 bit cleared");
    // R5: saturation both ways (refractory to keep the sum)
    send(mk(16'd900, 24'd800, 16'sd30000, 8'h03), 16'sd30000, 24'd800, "R5 positive clamp");
    send(mk(16'd900, 24'd800, -16'sd30000, 8'h03), -16'sd30000, 24'd800, "R5 negative clamp");
    // R11: timestamp wrap, elapsed 32
    send(mk(16'h0, 24'hFFFFF0, 16'd1500, 8'h01), 16'd0, 24'h000010, "R11 wrap");
    drain();

    // R9: random burst under back-pressure, order kept
    bpOn = 1'b1;
    for (int i = 0; i < 60; i++) begin
      logic [23:0] now;
      logic [23:0] last;
      now  = 24'($urandom);
      last = now - 24'($urandom_range(0, 5000));
      send(mk(now[15:0] + 16'($urandom_range(0, 40)) - 16'd20, last,
              16'($signed(16'($urandom_range(0, 16000))) - 16'sd8000),
              8'($urandom)),
           16'($urandom_range(0, 8000) - 4000), now, "R9 burst");
    end
    drain();
    bpOn = 1'b0;
    drain();
    checks++;
    if (qState.size() != 0) begin
      fails++;
      $display("FAIL R9 missing outputs: actual %0d pending expected 0", qState.size());
    end
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule